// File: doc/BRIEF.md
# Priority-Masked Interrupt Arbiter

This block sits between a bank of 64 interrupt sources and the two request inputs of a processor core. For each source it receives a pending level, an enable bit, a type bit, and a 4-bit priority. It produces two request levels: a fast request, and a normal request that is gated by a priority threshold. Each source's priority sits in a bus of 32-bit words, with eight 4-bit fields in each word.

Normal sources compete on priority. The block reports the winning source number and its priority, and raises the normal request only if the winner's priority is strictly above the 5-bit threshold. The all-ones threshold turns the masking off. Fast sources have no priority: the lowest-numbered eligible one is reported.

All outputs are registered once. Each output follows the inputs sampled at the previous rising clock edge. A surrounding register file reads the winner outputs to build its status and acknowledge logic.

Top module: `irq_prio_arb`

## Requirements
- R1: A source takes part in arbitration only when both its `pend_i` bit and its `en_i` bit are 1. A source that is pending but disabled, or enabled but not pending, changes no output.
- R2: An eligible source whose `fast_sel_i` bit is 1 belongs only to the fast path. An eligible source whose `fast_sel_i` bit is 0 belongs only to the normal path.
- R3: `fiq_o` and `fast_vld_o` are 1 exactly when at least one eligible fast source exists, whatever the value of `thresh_i`.
- R4: When `thresh_i` is 5'h1F, `irq_o` is 1 exactly when at least one eligible normal source exists, at any priority including 0.
- R5: For any other `thresh_i`, `irq_o` is 1 only if some eligible normal source has a priority strictly greater than `thresh_i`. A threshold from 15 to 30 therefore blocks every normal source.
- R6: `norm_idx_o` and `norm_pri_o` give the eligible normal source with the largest priority. Among sources of equal priority, the higher source number wins. These outputs and `norm_vld_o` do not depend on `thresh_i`.
- R7: `fast_idx_o` gives the lowest-numbered eligible fast source.
- R8: The priority of source n is `prio_words_i[32*(n/8) + 4*(n%8) +: 4]`.
- R9: While `rst_n` is low, every output is 0. Otherwise, every output reflects the inputs sampled at the previous rising clock edge.
- R10: When no eligible normal source exists, `norm_vld_o`, `norm_idx_o` and `norm_pri_o` are 0. When no eligible fast source exists, `fast_vld_o` and `fast_idx_o` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pend_i | input | 64 | Pending level of each source |
| en_i | input | 64 | Enable bit of each source |
| fast_sel_i | input | 64 | Type bit of each source: 1 selects the fast path |
| prio_words_i | input | 256 | Eight 32-bit words of 4-bit priorities |
| thresh_i | input | 5 | Normal priority threshold; 5'h1F means no masking |
| irq_o | output | 1 | Normal request level |
| fiq_o | output | 1 | Fast request level |
| norm_vld_o | output | 1 | A normal winner exists |
| norm_idx_o | output | 6 | Normal winner source number |
| norm_pri_o | output | 4 | Normal winner priority |
| fast_vld_o | output | 1 | A fast winner exists |
| fast_idx_o | output | 6 | Fast winner source number |

## Verification
The block keeps only one registered copy of its outputs, so any wrong internal state shows at the ports in the cycle after the input that exposes it.

Each kind of fault has its own visible sign:
- An error in the comparison tree reports a winner that is not the highest-priority source, or breaks a tie toward the lower source number.
- A fault in the threshold logic raises `irq_o` for a source whose priority equals the threshold.
- A fault in the fast search reports a source number that is not the lowest one set.
- A fault in the priority unpacking moves a priority field to the wrong source, which changes the winner whenever priorities differ.

// File: rtl/irq_arb_pkg.sv
`timescale 1ns/1ps
package irq_arb_pkg;
   // Width of one word on the packed priority bus.
   localparam int unsigned PRIO_WORD_W = 32;

   // Structure used to locate the lowest eligible fast source.
   typedef enum logic [0:0] {
      FAST_TREE = 1'b0,
      FAST_SCAN = 1'b1
   } fast_impl_e;
endpackage

// File: rtl/irq_prio_unpack.sv
`timescale 1ns/1ps
// Spreads the packed priority words into one field per source.
module irq_prio_unpack #(
   parameter int unsigned N_SRC  = 64,
   parameter int unsigned PRIO_W = 4,
   parameter int unsigned WORD_W = 32,
   localparam int unsigned PER_WORD = WORD_W / PRIO_W,
   localparam int unsigned N_WORDS  = (N_SRC + PER_WORD - 1) / PER_WORD
) (
   input  logic [N_WORDS*WORD_W-1:0] words_i,
   output logic [N_SRC*PRIO_W-1:0]   prio_o
);
   for (genvar n = 0; n < N_SRC; n++) begin : g_src
      localparam int unsigned WRD = n / PER_WORD;
      localparam int unsigned SLT = n % PER_WORD;
      assign prio_o[n*PRIO_W +: PRIO_W] = words_i[WRD*WORD_W + SLT*PRIO_W +: PRIO_W];
   end
endmodule

// File: rtl/irq_max_tree.sv
`timescale 1ns/1ps
// Balanced comparison tree that selects the largest priority.
// On equal priorities the higher source number wins.
module irq_max_tree #(
   parameter int unsigned N_SRC  = 64,
   parameter int unsigned PRIO_W = 4,
   localparam int unsigned IDX_W  = (N_SRC > 1) ? $clog2(N_SRC) : 1,
   localparam int unsigned LEVELS = (N_SRC > 1) ? $clog2(N_SRC) : 1,
   localparam int unsigned LEAVES = 1 << LEVELS,
   localparam int unsigned NODES  = 2 * LEAVES - 1
) (
   input  logic [N_SRC-1:0]        req_i,
   input  logic [N_SRC*PRIO_W-1:0] prio_i,
   output logic                    vld_o,
   output logic [PRIO_W-1:0]       pri_o,
   output logic [IDX_W-1:0]        idx_o
);
   // Heap layout: node i has children 2i+1 and 2i+2.
   // The leaves start at node LEAVES-1.
   logic              nd_v [NODES];
   logic [PRIO_W-1:0] nd_p [NODES];
   logic [IDX_W-1:0]  nd_i [NODES];

   for (genvar k = 0; k < LEAVES; k++) begin : g_leaf
      if (k < N_SRC) begin : g_real
         assign nd_v[LEAVES-1+k] = req_i[k];
         assign nd_p[LEAVES-1+k] = prio_i[k*PRIO_W +: PRIO_W];
         assign nd_i[LEAVES-1+k] = IDX_W'(k);
      end else begin : g_pad
         assign nd_v[LEAVES-1+k] = 1'b0;
         assign nd_p[LEAVES-1+k] = '0;
         assign nd_i[LEAVES-1+k] = '0;
      end
   end

   for (genvar i = 0; i < LEAVES - 1; i++) begin : g_node
      localparam int unsigned LO = 2 * i + 1;
      localparam int unsigned HI = 2 * i + 2;
      logic pick_hi;
      // The HI child always covers higher source numbers, so ">=" breaks ties upward.
      assign pick_hi  = nd_v[HI] && (!nd_v[LO] || (nd_p[HI] >= nd_p[LO]));
      assign nd_v[i]  = nd_v[LO] | nd_v[HI];
      assign nd_p[i]  = pick_hi ? nd_p[HI] : nd_p[LO];
      assign nd_i[i]  = pick_hi ? nd_i[HI] : nd_i[LO];
   end

   assign vld_o = nd_v[0];
   assign pri_o = nd_p[0];
   assign idx_o = nd_i[0];
endmodule

// File: rtl/irq_first_set.sv
`timescale 1ns/1ps
// Finds the lowest set request bit, built either as a tree or as a scan.
module irq_first_set
   import irq_arb_pkg::*;
#(
   parameter int unsigned N_SRC = 64,
   parameter fast_impl_e  IMPL  = FAST_TREE,
   localparam int unsigned IDX_W  = (N_SRC > 1) ? $clog2(N_SRC) : 1,
   localparam int unsigned LEVELS = (N_SRC > 1) ? $clog2(N_SRC) : 1,
   localparam int unsigned LEAVES = 1 << LEVELS,
   localparam int unsigned NODES  = 2 * LEAVES - 1
) (
   input  logic [N_SRC-1:0] req_i,
   output logic             vld_o,
   output logic [IDX_W-1:0] idx_o
);
   if (IMPL == FAST_TREE) begin : g_tree
      logic             nd_v [NODES];
      logic [IDX_W-1:0] nd_i [NODES];

      for (genvar k = 0; k < LEAVES; k++) begin : g_leaf
         if (k < N_SRC) begin : g_real
            assign nd_v[LEAVES-1+k] = req_i[k];
            assign nd_i[LEAVES-1+k] = IDX_W'(k);
         end else begin : g_pad
            assign nd_v[LEAVES-1+k] = 1'b0;
            assign nd_i[LEAVES-1+k] = '0;
         end
      end

      for (genvar i = 0; i < LEAVES - 1; i++) begin : g_node
         localparam int unsigned LO = 2 * i + 1;
         localparam int unsigned HI = 2 * i + 2;
         // The lower half wins whenever it holds any request.
         assign nd_v[i] = nd_v[LO] | nd_v[HI];
         assign nd_i[i] = nd_v[LO] ? nd_i[LO] : nd_i[HI];
      end

      assign vld_o = nd_v[0];
      assign idx_o = nd_i[0];
   end else begin : g_scan
      always_comb begin
         idx_o = '0;
         for (int n = N_SRC - 1; n >= 0; n--) begin
            if (req_i[n]) idx_o = IDX_W'(n);
         end
      end
      assign vld_o = |req_i;
   end
endmodule

// File: rtl/irq_prio_arb.sv
`timescale 1ns/1ps
// Top level: splits sources into the two paths, arbitrates each, applies the threshold, registers the results.
module irq_prio_arb
   import irq_arb_pkg::*;
#(
   parameter int unsigned N_SRC     = 64,
   parameter int unsigned PRIO_W    = 4,
   parameter int unsigned THR_W     = 5,
   parameter int unsigned WORD_W    = PRIO_WORD_W,
   parameter fast_impl_e  FAST_IMPL = FAST_TREE,
   localparam int unsigned IDX_W    = (N_SRC > 1) ? $clog2(N_SRC) : 1,
   localparam int unsigned PER_WORD = WORD_W / PRIO_W,
   localparam int unsigned N_WORDS  = (N_SRC + PER_WORD - 1) / PER_WORD
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic [N_SRC-1:0]          pend_i,
   input  logic [N_SRC-1:0]          en_i,
   input  logic [N_SRC-1:0]          fast_sel_i,
   input  logic [N_WORDS*WORD_W-1:0] prio_words_i,
   input  logic [THR_W-1:0]          thresh_i,
   output logic                      irq_o,
   output logic                      fiq_o,
   output logic                      norm_vld_o,
   output logic [IDX_W-1:0]          norm_idx_o,
   output logic [PRIO_W-1:0]         norm_pri_o,
   output logic                      fast_vld_o,
   output logic [IDX_W-1:0]          fast_idx_o
);
   localparam logic [THR_W-1:0] THR_OPEN = {THR_W{1'b1}};

   // Parameter checks made at elaboration.
   if (N_SRC < 2) begin : g_err_nsrc
      $error("irq_prio_arb: N_SRC must be at least 2");
   end
   if ((WORD_W % PRIO_W) != 0) begin : g_err_word
      $error("irq_prio_arb: WORD_W must be a multiple of PRIO_W");
   end
   if (THR_W < PRIO_W) begin : g_err_thr
      $error("irq_prio_arb: THR_W must not be narrower than PRIO_W");
   end

   // Eligibility and routing to the two paths.
   logic [N_SRC-1:0] elig;
   logic [N_SRC-1:0] norm_req;
   logic [N_SRC-1:0] fast_req;

   assign elig     = pend_i & en_i;
   assign norm_req = elig & ~fast_sel_i;
   assign fast_req = elig &  fast_sel_i;

   logic [N_SRC*PRIO_W-1:0] prio_flat;

   irq_prio_unpack #(
      .N_SRC (N_SRC),
      .PRIO_W(PRIO_W),
      .WORD_W(WORD_W)
   ) u_unpack (
      .words_i(prio_words_i),
      .prio_o (prio_flat)
   );

   logic              n_vld;
   logic [PRIO_W-1:0] n_pri;
   logic [IDX_W-1:0]  n_idx;

   irq_max_tree #(
      .N_SRC (N_SRC),
      .PRIO_W(PRIO_W)
   ) u_norm (
      .req_i (norm_req),
      .prio_i(prio_flat),
      .vld_o (n_vld),
      .pri_o (n_pri),
      .idx_o (n_idx)
   );

   logic             f_vld;
   logic [IDX_W-1:0] f_idx;

   irq_first_set #(
      .N_SRC(N_SRC),
      .IMPL (FAST_IMPL)
   ) u_fast (
      .req_i(fast_req),
      .vld_o(f_vld),
      .idx_o(f_idx)
   );

   // Threshold gate. The winner carries the largest priority, so comparing
   // it alone decides whether any eligible normal source is above the threshold.
   logic irq_nxt;
   always_comb begin
      if (thresh_i == THR_OPEN) irq_nxt = n_vld;
      else                      irq_nxt = n_vld && (THR_W'(n_pri) > thresh_i);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         irq_o      <= 1'b0;
         fiq_o      <= 1'b0;
         norm_vld_o <= 1'b0;
         norm_idx_o <= '0;
         norm_pri_o <= '0;
         fast_vld_o <= 1'b0;
         fast_idx_o <= '0;
      end else begin
         irq_o      <= irq_nxt;
         fiq_o      <= f_vld;
         norm_vld_o <= n_vld;
         norm_idx_o <= n_vld ? n_idx : '0;
         norm_pri_o <= n_vld ? n_pri : '0;
         fast_vld_o <= f_vld;
         fast_idx_o <= f_vld ? f_idx : '0;
      end
   end
endmodule

// File: rtl/irq_prio_arb_chk.sv
`timescale 1ns/1ps
// Checker for irq_prio_arb, attached to every instance by the bind at the end of this file.
module irq_prio_arb_chk #(
   parameter int unsigned N_SRC   = 64,
   parameter int unsigned PRIO_W  = 4,
   parameter int unsigned THR_W   = 5,
   parameter int unsigned IDX_W   = 6,
   parameter int unsigned BUS_W   = 256
) (
   input logic              clk,
   input logic              rst_n,
   input logic [N_SRC-1:0]  pend_i,
   input logic [N_SRC-1:0]  en_i,
   input logic [N_SRC-1:0]  fast_sel_i,
   input logic [BUS_W-1:0]  prio_words_i,
   input logic [THR_W-1:0]  thresh_i,
   input logic              irq_o,
   input logic              fiq_o,
   input logic              norm_vld_o,
   input logic [IDX_W-1:0]  norm_idx_o,
   input logic [PRIO_W-1:0] norm_pri_o,
   input logic              fast_vld_o,
   input logic [IDX_W-1:0]  fast_idx_o
);
   localparam logic [THR_W-1:0] OPEN = {THR_W{1'b1}};
   localparam logic [N_SRC-1:0] ONE  = N_SRC'(1);

   logic [N_SRC-1:0] c_norm;
   logic [N_SRC-1:0] c_fast;
   assign c_norm = pend_i & en_i & ~fast_sel_i;
   assign c_fast = pend_i & en_i &  fast_sel_i;

   // R3: the fast request follows eligible fast sources one cycle later.
   a_r3_fiq_follows: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (fiq_o == ($past(c_fast) != '0)));

   // R3: the fast request and the fast valid flag always agree.
   a_r3_fiq_vld_agree: assert property (@(posedge clk) disable iff (!rst_n)
      fiq_o == fast_vld_o);

   // R7: the fast winner is set, and no lower-numbered fast source is set.
   a_r7_fast_lowest: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (!fast_vld_o ||
                ((($past(c_fast) >> fast_idx_o) & ONE) == ONE &&
                 ($past(c_fast) & ((ONE << fast_idx_o) - ONE)) == '0)));

   // R4: with the open threshold, the normal request follows any eligible normal source.
   a_r4_open_mask: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (($past(thresh_i) != OPEN) || (irq_o == ($past(c_norm) != '0))));

   // R5: a masked normal request implies a winner strictly above the threshold.
   a_r5_strict_above: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (!irq_o || ($past(thresh_i) == OPEN) ||
                (THR_W'(norm_pri_o) > $past(thresh_i))));

   // R5: the normal request never fires without a normal winner.
   a_r5_irq_needs_winner: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o |-> norm_vld_o);

   // R6: the reported normal winner was an eligible normal source.
   a_r6_winner_eligible: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (!norm_vld_o || (($past(c_norm) >> norm_idx_o) & ONE) == ONE));

   // R10: with no normal winner, index and priority read as zero.
   a_r10_norm_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !norm_vld_o |-> (norm_idx_o == '0 && norm_pri_o == '0));

   // R10: with no fast winner, the fast index reads as zero.
   a_r10_fast_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !fast_vld_o |-> (fast_idx_o == '0));

   // R9: outputs are cleared in the cycle after reset is applied.
   a_r9_reset_clear: assert property (@(posedge clk)
      !rst_n |=> (!irq_o && !fiq_o && !norm_vld_o && !fast_vld_o));

   // Keep the inputs the properties do not reference from raising warnings.
   logic unused_ok;
   assign unused_ok = ^prio_words_i;
endmodule

bind irq_prio_arb irq_prio_arb_chk #(
   .N_SRC (N_SRC),
   .PRIO_W(PRIO_W),
   .THR_W (THR_W),
   .IDX_W (IDX_W),
   .BUS_W (N_WORDS*WORD_W)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .pend_i      (pend_i),
   .en_i        (en_i),
   .fast_sel_i  (fast_sel_i),
   .prio_words_i(prio_words_i),
   .thresh_i    (thresh_i),
   .irq_o       (irq_o),
   .fiq_o       (fiq_o),
   .norm_vld_o  (norm_vld_o),
   .norm_idx_o  (norm_idx_o),
   .norm_pri_o  (norm_pri_o),
   .fast_vld_o  (fast_vld_o),
   .fast_idx_o  (fast_idx_o)
);

// File: tb/test_irq_prio_arb.sv
`timescale 1ns/1ps
module test_irq_prio_arb;
   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [63:0]  pend_i = '0;
   logic [63:0]  en_i = '0;
   logic [63:0]  fast_sel_i = '0;
   logic [255:0] prio_words_i = '0;
   logic [4:0]   thresh_i = 5'h1F;
   logic         irq_o, fiq_o, norm_vld_o, fast_vld_o;
   logic [5:0]   norm_idx_o, fast_idx_o;
   logic [3:0]   norm_pri_o;

   irq_prio_arb i_irq_prio_arb (
      .clk(clk), .rst_n(rst_n), .pend_i(pend_i), .en_i(en_i),
      .fast_sel_i(fast_sel_i), .prio_words_i(prio_words_i), .thresh_i(thresh_i),
      .irq_o(irq_o), .fiq_o(fiq_o), .norm_vld_o(norm_vld_o),
      .norm_idx_o(norm_idx_o), .norm_pri_o(norm_pri_o),
      .fast_vld_o(fast_vld_o), .fast_idx_o(fast_idx_o)
   );

   always #2 clk = ~clk;  // 250 MHz

   typedef struct packed {
      logic       irq;
      logic       fiq;
      logic       nv;
      logic [5:0] ni;
      logic [3:0] np;
      logic       fv;
      logic [5:0] fi;
   } exp_t;

   exp_t exp_q[$];
   int   total = 0;
   int   bad = 0;
   bit   finished = 0;

   // Stimulus staging area used by the driver.
   logic [63:0] s_pend, s_en, s_fast;
   logic [3:0]  s_pr [64];
   logic [4:0]  s_thr;

   task automatic chk(input string what, input int act, input int expv);
      total++;
      if (act != expv) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", what, act, expv, $time);
      end
   endtask

   task automatic clear_stage();
      s_pend = '0; s_en = '0; s_fast = '0; s_thr = 5'h1F;
      for (int n = 0; n < 64; n++) s_pr[n] = '0;
   endtask

   // Driver: computes the expected result from the requirements, then applies the stimulus.
   task automatic apply_vec();
      exp_t e;
      logic [255:0] bus;
      e = '0;
      bus = '0;
      for (int n = 0; n < 64; n++) begin
         // R8: source n lives in word n/8 at nibble n%8.
         bus[32*(n/8) + 4*(n%8) +: 4] = s_pr[n];
         if (s_pend[n] && s_en[n] && !s_fast[n]) begin
            // R6: ascending walk with ">=" leaves the highest number on ties.
            if (!e.nv || s_pr[n] >= e.np) begin
               e.nv = 1'b1; e.np = s_pr[n]; e.ni = 6'(n);
            end
            if (s_thr == 5'h1F) e.irq = 1'b1;                 // R4
            else if ({1'b0, s_pr[n]} > s_thr) e.irq = 1'b1;   // R5
         end
         if (s_pend[n] && s_en[n] && s_fast[n] && !e.fv) begin
            e.fv = 1'b1; e.fi = 6'(n); e.fiq = 1'b1;          // R3, R7
         end
      end
      @(negedge clk);
      pend_i = s_pend; en_i = s_en; fast_sel_i = s_fast;
      prio_words_i = bus; thresh_i = s_thr;
      exp_q.push_back(e);
   endtask

   // Monitor: each vector is registered at the next rising edge and compared 1 ns later.
   initial begin
      @(posedge rst_n);
      forever begin
         @(posedge clk);
         #1;
         if (exp_q.size() > 0) begin
            exp_t e;
            e = exp_q.pop_front();
            chk("R4/R5 irq_o", int'(irq_o), int'(e.irq));
            chk("R3 fiq_o", int'(fiq_o), int'(e.fiq));
            chk("R3 fast_vld_o", int'(fast_vld_o), int'(e.fv));
            chk("R6 norm_vld_o", int'(norm_vld_o), int'(e.nv));
            chk("R6 norm_idx_o", int'(norm_idx_o), int'(e.ni));
            chk("R6 norm_pri_o", int'(norm_pri_o), int'(e.np));
            chk("R7 fast_idx_o", int'(fast_idx_o), int'(e.fi));
         end
      end
   end

   initial begin
      #(4 * 150000);
      if (!finished) begin
         bad++;
         total++;
         $display("FAIL watchdog expired actual=hung expected=done");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      clear_stage();
      repeat (3) @(posedge clk);
      #1;
      // R9: every output is zero during reset.
      chk("R9 reset irq_o", int'(irq_o), 0);
      chk("R9 reset fiq_o", int'(fiq_o), 0);
      chk("R9 reset norm_vld_o", int'(norm_vld_o), 0);
      chk("R9 reset fast_vld_o", int'(fast_vld_o), 0);
      @(negedge clk);
      rst_n = 1'b1;

      // R10: nothing eligible, so all outputs are zero.
      clear_stage(); apply_vec();
      // R1: pending but disabled, and enabled but not pending.
      clear_stage(); s_pend[7] = 1'b1; s_en[8] = 1'b1; s_fast[8] = 1'b1; s_pr[7] = 4'd9; apply_vec();
      // R4: one normal source at priority 3 with the open threshold.
      clear_stage(); s_pend[5] = 1'b1; s_en[5] = 1'b1; s_pr[5] = 4'd3; apply_vec();
      // R5: a threshold equal to the priority blocks the request; the winner is still reported.
      s_thr = 5'd3; apply_vec();
      // R5: a threshold one below the priority passes.
      s_thr = 5'd2; apply_vec();
      // R5: a threshold of 20 blocks even priority 15.
      s_pr[5] = 4'd15; s_thr = 5'd20; apply_vec();
      s_thr = 5'd15; apply_vec();
      s_thr = 5'd14; apply_vec();
      // R6: a three-way tie resolves to the highest number.
      clear_stage();
      s_pend[10] = 1; s_en[10] = 1; s_pr[10] = 4'd7;
      s_pend[40] = 1; s_en[40] = 1; s_pr[40] = 4'd7;
      s_pend[63] = 1; s_en[63] = 1; s_pr[63] = 4'd7;
      s_pend[20] = 1; s_en[20] = 1; s_pr[20] = 4'd6;
      apply_vec();
      // R6: a higher priority at a lower number beats the tie group.
      s_pend[0] = 1; s_en[0] = 1; s_pr[0] = 4'd8; apply_vec();
      // R4: priority-zero sources with the open threshold still raise the request.
      clear_stage();
      s_pend[0] = 1; s_en[0] = 1; s_pend[1] = 1; s_en[1] = 1; apply_vec();
      // R4/R5: the same sources with threshold 0 do not raise it.
      s_thr = 5'd0; apply_vec();
      // R3, R7: fast sources ignore the threshold; the lowest number wins.
      clear_stage(); s_thr = 5'd0;
      s_pend[33] = 1; s_en[33] = 1; s_fast[33] = 1;
      s_pend[9]  = 1; s_en[9]  = 1; s_fast[9]  = 1;
      apply_vec();
      // R2: routing by type bit; source 2 is fast, source 60 is normal at a high priority.
      clear_stage();
      s_pend[2]  = 1; s_en[2]  = 1; s_fast[2] = 1; s_pr[2] = 4'd15;
      s_pend[60] = 1; s_en[60] = 1; s_pr[60] = 4'd4;
      apply_vec();
      // R7, R10: only source 63 is eligible, and it is fast.
      clear_stage(); s_pend[63] = 1; s_en[63] = 1; s_fast[63] = 1; apply_vec();
      // R8: a distinct priority in every nibble of one word.
      clear_stage();
      for (int n = 16; n < 24; n++) begin
         s_pend[n] = 1; s_en[n] = 1; s_pr[n] = 4'(15 - (n - 16));
      end
      apply_vec();
      s_pr[23] = 4'd15; apply_vec();
      // Mixed random patterns.
      for (int t = 0; t < 60; t++) begin
         clear_stage();
         s_pend = {$urandom(), $urandom()};
         s_en   = {$urandom(), $urandom()} | {$urandom(), $urandom()};
         s_fast = {$urandom(), $urandom()} & {$urandom(), $urandom()};
         if (t % 4 == 0) s_fast = '0;
         if (t % 5 == 0) s_en = s_en & {$urandom(), $urandom()} & {$urandom(), $urandom()};
         for (int n = 0; n < 64; n++) s_pr[n] = 4'($urandom());
         s_thr = (t % 3 == 0) ? 5'h1F : 5'($urandom() % 17);
         apply_vec();
      end
      clear_stage(); apply_vec();

      wait (exp_q.size() == 0);
      @(posedge clk); #2;
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule